// File: doc/BRIEF.md
# Command-Driven Serial Byte Transmitter with Automatic XON

This block turns 16-bit host command words into bytes on a single serial transmit line. The line uses a fixed asynchronous frame of one start bit, eight data bits, no parity and one stop bit. The bit period is `CLK_HZ/BAUD` clock cycles, and the default rate is 9600 baud, so one byte takes about a millisecond. A command with the transmit-request flag set sends the upper byte of the command word. Bit 0 of that byte goes out first.

The block also tracks whether the host has put the link into receive mode. On the first accepted command that enables receive mode, the block sends the flow-control character XON (0x11) by itself. This tells the far end it may start sending. XOFF (0x13) is never produced automatically. The host sends it as an ordinary data byte when it needs it.

There is a single one-byte transmit buffer. While a frame is on the line, any command that arrives is dropped in full. That includes any change it would make to receive mode.

Top module: `cmd_uart_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx` is high and `busy` is low.
- R2: A frame is a low start bit, eight data bits least significant first, and a high stop bit. Each bit lasts exactly `CLK_HZ/BAUD` cycles.
- R3: An accepted command with bit 6 (transmit request) set sends `cmd_word[15:8]`. For example, 0xF0C0 sends 0xF0.
- R4: `busy` rises on the clock edge that accepts a command that launches a frame. It stays high for exactly 10 bit periods.
- R5: A command presented while `busy` is high is ignored. It sends no byte and does not change receive mode.
- R6: An accepted command with bit 4 (receive enable) set, arriving while receive mode is off, turns receive mode on and sends XON (0x11). Further receive-enable commands while the mode is on send no XON.
- R7: An accepted command with bit 4 clear leaves receive mode. This re-arms XON for the next entry.
- R8: If a command both enters receive mode and requests a transmit, only XON is sent. The requested data byte is dropped.
- R9: XOFF (0x13) is sent only when the host requests it as a data byte.
- R10: An accepted command with bit 6 clear that does not enter receive mode sends nothing.
- R11: A command presented in the first cycle that `busy` reads low after a frame is accepted, and starts the next frame at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command word strobe, one cycle per command |
| cmd_word | input | 16 | Command: [15:8] data byte, [6] transmit request, [4] receive enable |
| tx | output | 1 | Serial transmit line, idles high |
| busy | output | 1 | High from start bit through end of stop bit |

## Verification
The hardest state to reach from the ports is a dropped command whose only effect would have been on receive mode. Nothing on the line shows that it was ignored. The stimulus enters receive mode, which produces an XON frame. While that frame is still on the line, it injects a receive-disable command. After the frame ends, it sends another receive-enable command. If the dropped command had leaked through, a second XON would appear, and the scoreboard would see an unexpected frame. A back-to-back pair is also driven in the very first idle cycle, to catch any gap or loss at the end of the frame.

// File: rtl/cmd_uart_pkg.sv
// Shared constants for the command-driven serial transmitter.
// Assumes a 16-bit command word with the data byte in the upper half.
package cmd_uart_pkg;
    localparam int          CMD_W      = 16;
    localparam int          TXREQ_BIT  = 6;
    localparam int          RXEN_BIT   = 4;
    localparam int          FRAME_BITS = 10;
    localparam logic [7:0]  XON_CHAR   = 8'h11;
endpackage

// File: rtl/cmd_uart_baud.sv
// Bit-period divider: while run is high, it pulses tick once every BIT_CYC
// cycles. restart re-aligns the period to the start of a new frame.
// Assumes BIT_CYC >= 2.
module cmd_uart_baud #(
    parameter int BIT_CYC = 13020
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int CW = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(BIT_CYC - 1);

    logic [CW-1:0] cnt;

    // Count cycles within the current bit period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            cnt <= '0;
        else if (run)
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);

    // R2: the divider never leaves its legal range
    a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/cmd_uart_shift.sv
// Frame shifter: it loads start, data and stop bits and shifts one bit per
// tick, least significant first. busy covers the whole frame.
// Assumes load is only raised while busy is low.
module cmd_uart_shift
    import cmd_uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       tick,
    output logic       tx,
    output logic       busy
);
    logic [FRAME_BITS-1:0] shreg;
    logic [3:0]            idx;

    // Load a new frame, or advance the current one on each bit tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '1;
            idx   <= '0;
            busy  <= 1'b0;
        end else if (load) begin
            shreg <= {1'b1, load_byte, 1'b0};
            idx   <= '0;
            busy  <= 1'b1;
        end else if (tick) begin
            shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
            if (idx == 4'(FRAME_BITS - 1)) begin
                idx  <= '0;
                busy <= 1'b0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    assign tx = shreg[0];

    // R5: no new frame is loaded over one in flight
    a_r5_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !load);
    // R1: the line idles high
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx);
    // R2: every frame opens with a low start bit
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !tx);
    // R2: the line only changes on bit boundaries
    a_r2_hold_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(tx));
endmodule

// File: rtl/cmd_uart_decode.sv
// Command decoder: it accepts commands only while idle, tracks receive mode,
// and picks XON or the command's data byte for the next frame.
// Assumes cmd_valid is a single-cycle strobe.
module cmd_uart_decode
    import cmd_uart_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_word,
    input  logic             busy,
    output logic             load,
    output logic [7:0]       load_byte
);
    logic rx_mode;
    logic accept;
    logic xon_go;

    assign accept    = cmd_valid && !busy;
    assign xon_go    = accept && cmd_word[RXEN_BIT] && !rx_mode;
    assign load      = xon_go || (accept && cmd_word[TXREQ_BIT]);
    assign load_byte = xon_go ? XON_CHAR : cmd_word[CMD_W-1:CMD_W-8];

    // Track receive mode from accepted commands only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_mode <= 1'b0;
        else if (accept)
            rx_mode <= cmd_word[RXEN_BIT];
    end

    // R6: entering receive mode always launches a frame (the XON)
    a_r6_entry_sends: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_mode) |-> busy);
    // R5: receive mode does not change while a frame was in flight
    a_r5_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> $stable(rx_mode));
    // R10: nothing is launched without a command
    a_r10_load_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> cmd_valid);
endmodule

// File: rtl/cmd_uart_tx.sv
// Top: a command-driven 8N1 serial transmitter with automatic XON on the
// first entry into receive mode. The bit period is CLK_HZ/BAUD cycles.
module cmd_uart_tx
    import cmd_uart_pkg::*;
#(
    parameter int CLK_HZ = 125_000_000,
    parameter int BAUD   = 9600
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_word,
    output logic             tx,
    output logic             busy
);
    localparam int BIT_CYC = CLK_HZ / BAUD;

    logic       load;
    logic [7:0] load_byte;
    logic       tick;

    cmd_uart_decode u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .busy      (busy),
        .load      (load),
        .load_byte (load_byte)
    );

    cmd_uart_baud #(.BIT_CYC(BIT_CYC)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .run     (busy),
        .tick    (tick)
    );

    cmd_uart_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_byte (load_byte),
        .tick      (tick),
        .tx        (tx),
        .busy      (busy)
    );
endmodule

// File: tb/cmd_uart_tx_tb.sv
module cmd_uart_tx_tb;
    localparam int CLK_HZ  = 76800;
    localparam int BAUD    = 9600;
    localparam int BIT_CYC = CLK_HZ / BAUD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic        tx;
    logic        busy;

    int n_chk = 0;
    int n_fail = 0;
    logic  [7:0] exp_q[$];
    string       req_q[$];
    logic        mon_en = 1'b0;

    always #4 clk = ~clk;

    cmd_uart_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
        .cmd_word(cmd_word), .tx(tx), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Driver: wait for idle, present one command, and queue the expected byte.
    task automatic send(input logic [15:0] w, input bit has_exp,
                        input logic [7:0] b, input string req);
        @(negedge clk);
        while (busy) @(negedge clk);
        cmd_word = w; cmd_valid = 1'b1;
        if (has_exp) begin exp_q.push_back(b); req_q.push_back(req); end
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Present a command while a frame is in flight (it must be ignored).
    task automatic send_busy(input logic [15:0] w);
        @(negedge clk);
        while (!busy) @(negedge clk);
        repeat (3) @(negedge clk);
        cmd_word = w; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (4 * BIT_CYC) @(negedge clk);
    endtask

    // Monitor: decode each frame at mid-bit and compare with the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en && tx == 1'b0) begin
                logic [7:0] got;
                logic [7:0] e;
                string r;
                got = '0;
                repeat (BIT_CYC/2 - 1) @(negedge clk);
                check(tx == 1'b0, "R2 start bit", tx, 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (BIT_CYC) @(negedge clk);
                    got[i] = tx;
                end
                repeat (BIT_CYC) @(negedge clk);
                check(tx == 1'b1, "R2 stop bit", tx, 1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5/R10 unexpected frame", got, 0);
                end else begin
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    check(got == e, r, got, e);
                end
            end
        end
    end

    // R4: every busy pulse lasts exactly ten bit periods.
    initial begin
        int len = 0;
        forever begin
            @(negedge clk);
            if (busy) len++;
            else if (len != 0) begin
                check(len == 10 * BIT_CYC, "R4 busy length", len, 10 * BIT_CYC);
                len = 0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx == 1'b1, "R1 reset tx", tx, 1);
        check(busy == 1'b0, "R1 reset busy", busy, 0);
        mon_en = 1'b1;

        // R3: data byte from the upper half, several patterns
        send(16'hF0C0, 1, 8'hF0, "R3 F0C0");
        send(16'h5540, 1, 8'h55, "R3 55");
        send(16'h0140, 1, 8'h01, "R2 lsb first 01");
        send(16'h8040, 1, 8'h80, "R2 msb last 80");
        wait_done();

        // R10: no transmit request, no receive entry
        send(16'h7700, 0, 8'h00, "");
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R10 no frame", busy, 0);

        // R6: receive entry sends XON; R5: commands during it are ignored
        send(16'h0010, 1, 8'h11, "R6 XON on entry");
        send_busy(16'hAA40);
        send_busy(16'h0000);
        wait_done();
        send(16'h0010, 0, 8'h00, "");
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R5/R6 no second XON", busy, 0);
        send(16'h3C50, 1, 8'h3C, "R6 data while in receive mode");
        wait_done();

        // R7 re-arm, then R8: entry plus transmit request sends XON only
        send(16'h0000, 0, 8'h00, "");
        send(16'h9950, 1, 8'h11, "R7/R8 XON only");
        // R9: XOFF only as explicit data
        send(16'h1340, 1, 8'h13, "R9 explicit XOFF");

        // R11: command in the first idle cycle is accepted
        @(negedge clk);
        while (busy) @(negedge clk);
        cmd_word = 16'h5A40; cmd_valid = 1'b1;
        exp_q.push_back(8'h5A); req_q.push_back("R11 back-to-back");
        @(negedge clk);
        cmd_valid = 1'b0;
        check(busy == 1'b1, "R11 accepted at once", busy, 1);
        wait_done();

        check(exp_q.size() == 0, "R2 all frames seen", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule